// File: doc/BRIEF.md
# Cascadable Up/Down Counter Slice

A narrow binary counter slice that steps up or down by one on each rising clock edge while its active-low carry-in is asserted. A direction input selects the step sign. A clear input forces the count to zero. A load input copies a parallel data word into the count. The slice drives an active-low carry-out that falls when the count sits at the end of its range for the current direction and the slice is enabled. The end of the range is all ones when counting up and zero when counting down.

Wider counters are built by giving every slice the same clock and feeding each slice's carry-out into the carry-in of the next more significant slice. Carry-out is a purely combinational function of the registered count, the direction and the carry-in. It therefore settles once after each clock edge or input change, and the next slice samples it cleanly on the shared edge. Clear and load act on the clock edge with the priority clear, then load, then counting. A separate system reset, asserted asynchronously and released synchronously, puts the count at zero.

Top module: `updn_slice`

## Requirements
- R1: While `rst_ni` is low, `cnt_o` is zero without waiting for a clock edge. The count stays zero until `rst_ni` has been high for two rising edges.
- R2: A rising edge with `clr_i` high makes `cnt_o` zero. This overrides `load_i` and counting.
- R3: A rising edge with `clr_i` low and `load_i` high copies `data_i` into `cnt_o`, whatever `cin_ni` and `up_i` are.
- R4: A rising edge with `clr_i`, `load_i` low and `cin_ni` high leaves `cnt_o` unchanged.
- R5: A rising edge with `clr_i`, `load_i`, `cin_ni` low and `up_i` high adds one to `cnt_o`, wrapping from all ones to zero.
- R6: A rising edge with `clr_i`, `load_i`, `cin_ni` low and `up_i` low subtracts one from `cnt_o`, wrapping from zero to all ones.
- R7: `co_no` is low exactly when `cin_ni` is low and `cnt_o` is all ones with `up_i` high, or zero with `up_i` low. It is high otherwise and follows its inputs in the same cycle.
- R8: Two slices with a shared clock and control, where the low slice's `co_no` drives the high slice's `cin_ni`, behave as one counter of twice the width. The high slice's `co_no` marks the terminal count of the combined word.

Ports of the top module follow; `WIDTH` defaults to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | System reset, active low, asynchronous assert |
| clr_i | input | 1 | Clear count to zero, active high |
| load_i | input | 1 | Load `data_i` into count, active high |
| data_i | input | WIDTH | Parallel load value |
| up_i | input | 1 | Direction: 1 up, 0 down |
| cin_ni | input | 1 | Count enable / carry-in, active low |
| cnt_o | output | WIDTH | Current count |
| co_no | output | 1 | Carry-out, active low |

## Verification
Clear, load, hold and step results show on `cnt_o` one rising edge after the inputs that cause them. The reference model advances on that same edge, and the comparison runs on the following falling edge, after the registers settle and before new stimulus goes out. Carry-out needs no clock, so it is compared at the same falling edge against the count and inputs present then. The asynchronous reset clear is sampled one time unit after `rst_ni` falls, between edges. After reset release the stimulus stays idle for three edges so the two-stage release synchroniser cannot move the comparison point.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } updn_op_e;
endpackage

// File: rtl/updn_rst_sync.sv
module updn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_no = sync_q[STAGES-1];
endmodule

// File: rtl/updn_next.sv
module updn_next
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             cin_ni,
  input  logic             up_i,
  output logic [WIDTH-1:0] nxt_o,
  output logic             en_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  updn_op_e op;

  always_comb begin
    if (clr_i)        op = OP_CLEAR;
    else if (load_i)  op = OP_LOAD;
    else if (!cin_ni) op = OP_STEP;
    else              op = OP_HOLD;
  end

  always_comb begin
    en_o  = 1'b1;
    nxt_o = cnt_i;
    unique case (op)
      OP_CLEAR: nxt_o = '0;
      OP_LOAD:  nxt_o = data_i;
      OP_STEP:  nxt_o = up_i ? cnt_i + ONE : cnt_i - ONE;
      default:  en_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/updn_term.sv
module updn_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             up_i,
  input  logic             cin_ni,
  output logic             co_no
);
  logic at_top, at_bottom, at_end;

  assign at_top    = &cnt_i;
  assign at_bottom = ~|cnt_i;
  assign at_end    = up_i ? at_top : at_bottom;
  assign co_no     = ~(at_end & ~cin_ni);
endmodule

// File: rtl/updn_slice.sv
module updn_slice #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_i,
  input  logic             cin_ni,
  output logic [WIDTH-1:0] cnt_o,
  output logic             co_no
);
  logic             srst_n;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  updn_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_no (srst_n)
  );

  updn_next #(.WIDTH(WIDTH)) u_next (
    .cnt_i  (cnt_q),
    .data_i (data_i),
    .clr_i  (clr_i),
    .load_i (load_i),
    .cin_ni (cin_ni),
    .up_i   (up_i),
    .nxt_o  (cnt_d),
    .en_o   (cnt_en)
  );

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  updn_term #(.WIDTH(WIDTH)) u_term (
    .cnt_i  (cnt_q),
    .up_i   (up_i),
    .cin_ni (cin_ni),
    .co_no  (co_no)
  );

  assign cnt_o = cnt_q;
endmodule

// File: rtl/updn_slice_chk.sv
module updn_slice_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             srst_n,
  input logic             clr,
  input logic             load,
  input logic [WIDTH-1:0] data,
  input logic             up,
  input logic             cin_n,
  input logic [WIDTH-1:0] cnt,
  input logic             co_n
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // R1: count is zero while the synchronised reset is held
  a_r1_reset_zero: assert property (@(posedge clk) !srst_n |-> cnt == '0);

  a_r2_clear: assert property (@(posedge clk) disable iff (!srst_n)
    clr |=> cnt == '0);

  a_r3_load: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr && load) |=> cnt == $past(data));

  a_r4_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr && !load && cin_n) |=> $stable(cnt));

  a_r5_up: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr && !load && !cin_n && up) |=> cnt == $past(cnt) + ONE);

  a_r6_down: assert property (@(posedge clk) disable iff (!srst_n)
    (!clr && !load && !cin_n && !up) |=> cnt == $past(cnt) - ONE);

  a_r7_co_needs_cin: assert property (@(posedge clk) disable iff (!srst_n)
    !co_n |-> !cin_n);

  a_r7_co_up_wraps: assert property (@(posedge clk) disable iff (!srst_n)
    (!co_n && up && !clr && !load) |=> cnt == '0);

  a_r7_co_down_wraps: assert property (@(posedge clk) disable iff (!srst_n)
    (!co_n && !up && !clr && !load) |=> &cnt);
endmodule

bind updn_slice updn_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk_i),
  .srst_n (srst_n),
  .clr    (clr_i),
  .load   (load_i),
  .data   (data_i),
  .up     (up_i),
  .cin_n  (cin_ni),
  .cnt    (cnt_o),
  .co_n   (co_no)
);

// File: tb/updn_slice_tb.sv
`timescale 1ns/1ps
module updn_slice_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0, load = 1'b0, up = 1'b1, cin_n = 1'b1;
  logic [7:0] data = 8'h00;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_co_n, hi_co_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  string tag = "R4";
  int model = 0;

  always #5 clk = ~clk;

  updn_slice #(.WIDTH(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_i(load),
    .data_i(data[3:0]), .up_i(up), .cin_ni(cin_n),
    .cnt_o(lo_cnt), .co_no(lo_co_n));

  updn_slice #(.WIDTH(4)) u_hi (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .load_i(load),
    .data_i(data[7:4]), .up_i(up), .cin_ni(lo_co_n),
    .cnt_o(hi_cnt), .co_no(hi_co_n));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // reference model: 8-bit behavioural counter
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       model = 0;
    else if (clr)     model = 0;
    else if (load)    model = data;
    else if (!cin_n)  model = up ? (model + 1) % 256 : (model + 255) % 256;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(tag, {hi_cnt, lo_cnt}, model);
      check("R7", lo_co_n,
            (!cin_n && (model % 16) == (up ? 15 : 0)) ? 0 : 1);
      check("R8", hi_co_n,
            (!cin_n && model == (up ? 255 : 0)) ? 0 : 1);
    end
  end

  task automatic drive(string t, bit c, bit l, bit u, bit ci, logic [7:0] d, int n);
    @(negedge clk); #1;
    tag = t; clr = c; load = l; up = u; cin_n = ci; data = d;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #2;
    rst_n = 1'b0;
    #1;
    check("R1", {hi_cnt, lo_cnt}, 0);
    check("R1", lo_co_n, 1);
    drive("R1", 0, 0, 1, 1, 8'h00, 2);
    rst_n = 1'b1;
    drive("R1", 0, 0, 1, 1, 8'h00, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {hi_cnt, lo_cnt}, 0);
    cmp_on = 1'b1;
    drive("R5", 0, 0, 1, 0, 8'h00, 300);   // R5 R8: up through 255 -> 0
    drive("R4", 0, 0, 1, 1, 8'h00, 10);    // R4 hold
    drive("R3", 0, 1, 0, 1, 8'h05, 1);     // R3 load with cin_n high
    drive("R6", 0, 0, 0, 0, 8'h00, 20);    // R6 down through 0 -> 255
    drive("R3", 0, 1, 1, 0, 8'hEE, 1);     // R3 load beats counting
    drive("R5", 0, 0, 1, 0, 8'h00, 40);
    drive("R2", 1, 1, 1, 0, 8'h77, 2);     // R2 clear beats load
    drive("R6", 0, 0, 0, 0, 8'h00, 5);
    drive("R3", 0, 1, 0, 0, 8'h10, 1);
    drive("R6", 0, 0, 0, 0, 8'h00, 3);     // borrow across slices
    drive("R5", 0, 0, 1, 0, 8'h00, 6);     // direction swap
    drive("R4", 0, 0, 0, 1, 8'h00, 4);
    drive("R3", 0, 1, 1, 1, 8'h0F, 1);
    drive("R5", 0, 0, 1, 0, 8'h00, 3);
    drive("R6", 0, 0, 0, 0, 8'h00, 4);
    drive("R5", 0, 0, 1, 0, 8'h00, 20);
    do_reset();
    drive("R5", 0, 0, 1, 0, 8'h00, 10);
    drive("R6", 0, 0, 0, 0, 8'h00, 300);
    @(negedge clk);
    cmp_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule